// File: doc/BRIEF.md
# Half-Slot Pattern Generator

This block repeats a fixed bit pattern at half-clock resolution. Each bit of the pattern lasts for one half period of the input clock. The pattern is set at compile time, so the output toggles at up to twice the clock rate without a frequency multiplier or a phase-locked loop. The output is meant to drive a clock pin downstream, so it may change only once per half period, right after a clock edge.

The pattern is split by bit position. The bits in even slots rotate through a register clocked on the rising edge. The bits in odd slots rotate through a register clocked on the falling edge. A combining stage captures the even bit on the rising edge and the odd bit on the falling edge. It merges the two captures with an exclusive-or, so each edge changes only one input of the output gate. The same stage also produces a level-tracking signal that follows the clock: high in the high phase and low in the low phase, while the block runs.

A two-state sequencer controls start and restart. ST_IDLE holds both registers at their load values and keeps the output low. The transition "start" (ST_IDLE to ST_RUN) happens on the first rising edge that samples reset low. The transition "restart" (ST_RUN to ST_IDLE) happens on any rising edge that samples reset high.

Top module: `hsp_gen`

## Requirements
- R1: With PATTERN of even length PAT_LEN, the output repeats with a period of PAT_LEN half-periods, which is PAT_LEN/2 clock periods, for as long as reset stays low.
- R2: Half-slot k carries PATTERN[k], with bit 0 the first bit emitted. Slot 0 is the high phase that follows the first rising edge that samples reset low.
- R3: The even-slot bits (PATTERN[0], PATTERN[2], ...) appear in the high phases, in order, and advance one step per rising edge.
- R4: While running, lvl_track is 1 throughout each high phase and 0 throughout each low phase.
- R5: The odd-slot bits (PATTERN[1], PATTERN[3], ...) appear in the low phases, in order, and advance one step per falling edge.
- R6: While reset is held, pat_out and lvl_track are 0 from the first falling edge after reset is sampled.
- R7: A reset applied mid-run makes the next run start again at PATTERN[0], whatever slot was showing before.
- R8: pat_out is constant from 2 ns after each clock edge until the next edge, so it changes at most once per half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high, sampled on the rising edge |
| pat_out | output | 1 | Pattern output, one bit per half period |
| lvl_track | output | 1 | Signal that follows the clock level while running |

## Verification
The checks that run on every edge cover three things. The level tracker must be high at each falling edge and low at each rising edge. The output must match the even bit captured at the last rising edge and the odd bit captured at the last falling edge. Each rotating register must keep its number of ones. Only the bench scenarios can show that the slot order starts at PATTERN[0] after both initial and mid-run resets, that it wraps correctly over several repetitions for two pattern lengths, and that the output stays flat across early, middle and late samples in every half period.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    // Sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // Clock edge that advances a rotating lane
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } lane_edge_t;

endpackage

// File: rtl/hsp_seq.sv
module hsp_seq
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic run
);

    seq_state_t st, st_nx;

    // next-state: start when reset is low, restart when it is high
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (!rst) st_nx = ST_RUN;
            ST_RUN:  if (rst)  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // outputs
    always_comb begin
        run = (st == ST_RUN);
    end

endmodule

// File: rtl/hsp_lane.sv
module hsp_lane
    import hsp_pkg::*;
#(
    parameter int         H    = 3,
    parameter logic [H-1:0] INIT = '0,
    parameter lane_edge_t EDGE = EDGE_RISE
) (
    input  logic clk,
    input  logic load,
    input  logic adv,
    output logic head
);

    logic [H-1:0] r;
    logic [H-1:0] rot;
    logic [H-1:0] r_nx;

    generate
        if (H == 1) begin : g_single
            assign rot = r;
        end else begin : g_multi
            assign rot = {r[0], r[H-1:1]};
        end
    endgenerate

    always_comb begin
        if (load)     r_nx = INIT;
        else if (adv) r_nx = rot;
        else          r_nx = r;
    end

    assign head = r[0];

    generate
        if (EDGE == EDGE_FALL) begin : g_fall
            always_ff @(negedge clk) r <= r_nx;

            // R5: rotation keeps the odd-slot contents intact
            a_r5_ones_kept: assert property (@(negedge clk) disable iff (load)
                adv |-> ($countones(r) == $countones(INIT)));
        end else begin : g_rise
            always_ff @(posedge clk) r <= r_nx;

            // R3: rotation keeps the even-slot contents intact
            a_r3_ones_kept: assert property (@(posedge clk) disable iff (load)
                adv |-> ($countones(r) == $countones(INIT)));
        end
    endgenerate

endmodule

// File: rtl/hsp_combine.sv
module hsp_combine (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ev_bit,
    input  logic od_bit,
    output logic pat_out,
    output logic lvl_track
);

    logic d_r, d_f;   // xor-coded capture halves
    logic t_r, t_f;   // level tracker halves
    logic ev_seen, od_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_r <= 1'b0;
            t_r <= 1'b0;
        end else begin
            d_r <= ev_bit ^ d_f;
            t_r <= ~t_r;
        end
    end

    always_ff @(negedge clk) begin
        if (!run) begin
            d_f <= 1'b0;
            t_f <= 1'b0;
        end else begin
            d_f <= od_bit ^ d_r;
            t_f <= t_r;
        end
    end

    // one term of each xor changes per edge
    assign pat_out   = d_r ^ d_f;
    assign lvl_track = t_r ^ t_f;

    // plain captures, kept only for the checks below
    always_ff @(posedge clk) ev_seen <= ev_bit;
    always_ff @(negedge clk) od_seen <= od_bit;

    a_r4_lvl_high: assert property (@(negedge clk) disable iff (rst)
        run |-> lvl_track);
    a_r4_lvl_low: assert property (@(posedge clk) disable iff (rst)
        run |-> !lvl_track);
    a_r3_high_even: assert property (@(negedge clk) disable iff (rst)
        run |-> (pat_out == ev_seen));
    a_r5_low_odd: assert property (@(posedge clk) disable iff (rst)
        run |-> (pat_out == od_seen));

endmodule

// File: rtl/hsp_gen.sv
module hsp_gen
    import hsp_pkg::*;
#(
    parameter int                 PAT_LEN = 6,
    parameter logic [PAT_LEN-1:0] PATTERN = 6'b011001
) (
    input  logic clk,
    input  logic rst,
    output logic pat_out,
    output logic lvl_track
);

    localparam int HALF = PAT_LEN / 2;

    function automatic logic [HALF-1:0] pick(input logic [PAT_LEN-1:0] p,
                                             input int off);
        logic [HALF-1:0] v;
        v = '0;
        for (int i = 0; i < HALF; i++) v[i] = p[2*i + off];
        return v;
    endfunction

    localparam logic [HALF-1:0] EV_INIT = pick(PATTERN, 0);
    localparam logic [HALF-1:0] OD_INIT = pick(PATTERN, 1);

    logic       run;
    logic [1:0] lane_bit;

    hsp_seq u_seq (
        .clk (clk),
        .rst (rst),
        .run (run)
    );

    // lane 0: even slots on rising edge; lane 1: odd slots on falling edge
    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            hsp_lane #(
                .H    (HALF),
                .INIT ((g == 0) ? EV_INIT : OD_INIT),
                .EDGE ((g == 0) ? EDGE_RISE : EDGE_FALL)
            ) u_lane (
                .clk  (clk),
                .load ((g == 0) ? rst : !run),
                .adv  ((g == 0) ? !rst : run),
                .head (lane_bit[g])
            );
        end
    endgenerate

    hsp_combine u_comb (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ev_bit    (lane_bit[0]),
        .od_bit    (lane_bit[1]),
        .pat_out   (pat_out),
        .lvl_track (lvl_track)
    );

endmodule

// File: tb/sim_hsp_gen.sv
module sim_hsp_gen;

    localparam int          L0 = 6;
    localparam logic [7:0]  P0 = 8'b0001_1001;   // 1,0,0,1,1,0
    localparam int          L1 = 8;
    localparam logic [7:0]  P1 = 8'b1000_1101;   // 1,0,1,1,0,0,0,1

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic out0, lvl0, out1, lvl1;
    int   nchk = 0;
    int   nerr = 0;
    bit   restarted = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hsp_gen #(.PAT_LEN(L0), .PATTERN(P0[L0-1:0])) u0 (
        .clk(clk), .rst(rst), .pat_out(out0), .lvl_track(lvl0));
    hsp_gen #(.PAT_LEN(L1), .PATTERN(P1[L1-1:0])) u1 (
        .clk(clk), .rst(rst), .pat_out(out1), .lvl_track(lvl1));

    function automatic logic exp_bit(input logic [7:0] p, input int len, input int slot);
        return p[slot % len];
    endfunction

    function automatic string slot_tag(input int len, input int slot);
        if (slot == 0)   return restarted ? "R7" : "R2";
        if (slot >= len) return "R1";
        return (slot % 2 == 0) ? "R3" : "R5";
    endfunction

    task automatic chk(input string tag, input string who, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, who, $time, act, exp);
        end
    endtask

    task automatic check_slot(input int slot, input bit mid);
        if (mid) begin
            chk(slot_tag(L0, slot), "u0", out0, exp_bit(P0, L0, slot));
            chk(slot_tag(L1, slot), "u1", out1, exp_bit(P1, L1, slot));
            chk("R4", "u0 lvl", lvl0, (slot % 2 == 0));
            chk("R4", "u1 lvl", lvl1, (slot % 2 == 0));
        end else begin
            chk("R8", "u0", out0, exp_bit(P0, L0, slot));
            chk("R8", "u1", out1, exp_bit(P1, L1, slot));
        end
    endtask

    task automatic run_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #2 check_slot(2*c, 1'b0);
            #3 check_slot(2*c, 1'b1);
            #3 check_slot(2*c, 1'b0);
            @(negedge clk);
            #2 check_slot(2*c + 1, 1'b0);
            #3 check_slot(2*c + 1, 1'b1);
            #3 check_slot(2*c + 1, 1'b0);
        end
    endtask

    task automatic reset_for(input int n);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #5;
            chk("R6", "u0", out0, 1'b0);
            chk("R6", "u1", out1, 1'b0);
            chk("R6", "u0 lvl", lvl0, 1'b0);
            @(posedge clk);
            #5;
            chk("R6", "u0", out0, 1'b0);
            chk("R6", "u1 lvl", lvl1, 1'b0);
        end
        rst = 1'b0;
    endtask

    initial begin
        int s;
        s = $urandom(32'h5EED);
        reset_for(2);
        run_cycles(20);          // several full repetitions of both patterns
        restarted = 1'b1;
        reset_for(1);
        run_cycles(1);           // shortest run
        reset_for(3);
        run_cycles(2);
        for (int k = 0; k < 8; k++) begin
            reset_for($urandom_range(1, 4));
            run_cycles($urandom_range(1, 30));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        #4_000_000;
        nerr++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule